// File: doc/BRIEF.md
# Four-Bit ALU Slice with Carry-Lookahead Outputs

This block is a purely combinational arithmetic logic unit slice that works on two 4-bit operands with active-high data. A 4-bit function code and a mode bit choose between sixteen bitwise Boolean functions and sixteen arithmetic functions that run through the carry chain. Carry in and carry out are both active low, so a high carry input means that no carry enters the slice.

Besides the result, the slice drives a ripple carry output and a pair of active-low group propagate and group generate signals. An external lookahead unit can combine these from several slices into wide fast adders. A flag that is high when every result bit is one lets the slice act as an equality comparator, and in the subtract code the carry output gives relative magnitude.

Internally, each bit forms two terms from its operand bits and the function code: a first term U = A | (S0 & B) | (S1 & ~B), and a second term V = A & ((S2 & ~B) | (S3 & B)). Logic mode returns the bitwise complement of U ^ V. Arithmetic mode returns the sum U + V plus the carry input.

Top module: `alu4_slice`

## Requirements
- R1: With `logic_mode` = 1, `result` is the bitwise function ~(U ^ V) with no carry between bits. Select code 0000 gives ~A, 0001 NOR, 0011 zero, 0110 XOR, 1001 XNOR, 1011 AND, 1100 all ones, 1110 OR and 1111 A.
- R2: With `logic_mode` = 0, `result` equals (U + V + c) mod 16, where c = 1 when `carry_in_n` = 0 and c = 0 when `carry_in_n` = 1.
- R3: In arithmetic mode the following codes hold. 1001 gives A + B (+1 with carry). 0110 gives A - B - 1, or A - B with carry. 1100 gives A + A, which shifts each bit one place toward the MSB. 0000 gives A, or A + 1 with carry. 1111 gives A - 1, or A with carry. 0011 gives all ones, or zero with carry.
- R4: `carry_out_n` is the inverse of the carry out of bit 3 of U + V + c.
- R5: In arithmetic mode with code 0110, `carry_out_n` reports magnitude. With `carry_in_n` = 1 it is low exactly when A > B. With `carry_in_n` = 0 it is high exactly when A < B.
- R6: `all_ones` is high exactly when all four `result` bits are 1. In arithmetic mode with code 0110 and `carry_in_n` = 1, this is exactly when A equals B.
- R7: `grp_prop_n` is low exactly when every bit of U is 1. `grp_gen_n` is low exactly when U + V carries out of bit 3 with no carry in. These combine with the carry input as c_out = G | (P & c).
- R8: `logic_mode` has no effect on `carry_out_n`, `grp_prop_n` or `grp_gen_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 4 | Operand A |
| op_b | input | 4 | Operand B |
| fn_sel | input | 4 | Function code; bit 3 is S3 and bit 0 is S0 |
| logic_mode | input | 1 | 1 selects bitwise functions, 0 selects arithmetic |
| carry_in_n | input | 1 | Active-low carry input |
| result | output | 4 | Function result F |
| carry_out_n | output | 1 | Active-low ripple carry output |
| grp_prop_n | output | 1 | Active-low group propagate |
| grp_gen_n | output | 1 | Active-low group generate |
| all_ones | output | 1 | High when every result bit is 1 |

## Verification
The checker's assertions are evaluated whenever an input changes. They cover the XOR function in logic mode, the add code against a direct sum, the subtract code's magnitude and equality reporting, and the relation between the carry output and the group propagate and generate outputs. Only the bench's scenarios can show that each of the other select codes picks the right function from the table. The bench sweeps every operand, code, mode and carry combination to show this, and it also shows that the mode bit leaves the carry-related outputs untouched.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    localparam int unsigned SEL_W = 4;

    typedef struct packed {
        logic s3;
        logic s2;
        logic s1;
        logic s0;
    } fn_sel_t;

endpackage

// File: rtl/alu4_operand_gen.sv
module alu4_operand_gen
    import alu4_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  fn_sel_t          sel_i,
    output logic [WIDTH-1:0] term_u_o,
    output logic [WIDTH-1:0] term_v_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            term_u_o[i] = a_i[i] | (sel_i.s0 & b_i[i]) | (sel_i.s1 & ~b_i[i]);
            term_v_o[i] = a_i[i] & ((sel_i.s2 & ~b_i[i]) | (sel_i.s3 & b_i[i]));
        end
    end

endmodule

// File: rtl/alu4_lookahead.sv
module alu4_lookahead #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] prop_i,
    input  logic [WIDTH-1:0] gen_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] bit_carry_o,
    output logic             cout_o,
    output logic             grp_prop_o,
    output logic             grp_gen_o
);

    always_comb begin
        logic c;
        c = cin_i;
        for (int i = 0; i < WIDTH; i++) begin
            bit_carry_o[i] = c;
            c = gen_i[i] | (prop_i[i] & c);
        end
        cout_o = c;
    end

    always_comb begin
        logic g;
        g = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            g = gen_i[i] | (prop_i[i] & g);
        end
        grp_gen_o  = g;
        grp_prop_o = &prop_i;
    end

endmodule

// File: rtl/alu4_result.sv
module alu4_result #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] term_u_i,
    input  logic [WIDTH-1:0] term_v_i,
    input  logic [WIDTH-1:0] bit_carry_i,
    input  logic             logic_mode_i,
    output logic [WIDTH-1:0] result_o,
    output logic             all_ones_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic half;
        assign half = term_u_i[i] ^ term_v_i[i];
        always_comb begin
            if (logic_mode_i) begin
                result_o[i] = ~half;
            end else begin
                result_o[i] = half ^ bit_carry_i[i];
            end
        end
    end

    assign all_ones_o = &result_o;

endmodule

// File: rtl/alu4_slice.sv
module alu4_slice
    import alu4_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [SEL_W-1:0] fn_sel,
    input  logic             logic_mode,
    input  logic             carry_in_n,
    output logic [WIDTH-1:0] result,
    output logic             carry_out_n,
    output logic             grp_prop_n,
    output logic             grp_gen_n,
    output logic             all_ones
);

    fn_sel_t          sel;
    logic [WIDTH-1:0] term_u;
    logic [WIDTH-1:0] term_v;
    logic [WIDTH-1:0] bit_carry;
    logic             cout;
    logic             grp_p;
    logic             grp_g;

    assign sel = fn_sel_t'(fn_sel);

    alu4_operand_gen #(.WIDTH(WIDTH)) u_opgen (
        .a_i      (op_a),
        .b_i      (op_b),
        .sel_i    (sel),
        .term_u_o (term_u),
        .term_v_o (term_v)
    );

    alu4_lookahead #(.WIDTH(WIDTH)) u_cla (
        .prop_i      (term_u),
        .gen_i       (term_v),
        .cin_i       (~carry_in_n),
        .bit_carry_o (bit_carry),
        .cout_o      (cout),
        .grp_prop_o  (grp_p),
        .grp_gen_o   (grp_g)
    );

    alu4_result #(.WIDTH(WIDTH)) u_res (
        .term_u_i     (term_u),
        .term_v_i     (term_v),
        .bit_carry_i  (bit_carry),
        .logic_mode_i (logic_mode),
        .result_o     (result),
        .all_ones_o   (all_ones)
    );

    assign carry_out_n = ~cout;
    assign grp_prop_n  = ~grp_p;
    assign grp_gen_n   = ~grp_g;

endmodule

// File: rtl/alu4_slice_chk.sv
module alu4_slice_chk #(
    parameter int unsigned WIDTH = 4
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [3:0]       fn_sel,
    input logic             logic_mode,
    input logic             carry_in_n,
    input logic [WIDTH-1:0] result,
    input logic             carry_out_n,
    input logic             grp_prop_n,
    input logic             grp_gen_n,
    input logic             all_ones
);

    logic [WIDTH:0] add_ref;
    logic           known;

    assign known   = !$isunknown({op_a, op_b, fn_sel, logic_mode, carry_in_n,
                                  result, carry_out_n, grp_prop_n, grp_gen_n, all_ones});
    assign add_ref = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, ~carry_in_n};

    always_comb begin
        if (known) begin
            AST_LOGIC_XOR: assert (!(logic_mode && fn_sel == 4'b0110) || result == (op_a ^ op_b))
                else $error("logic xor mismatch"); // R1
            AST_ADD_SUM: assert (!(!logic_mode && fn_sel == 4'b1001) || {~carry_out_n, result} == add_ref)
                else $error("add mismatch"); // R3
            AST_SUB_MAGNITUDE: assert (!(!logic_mode && fn_sel == 4'b0110 && carry_in_n) || carry_out_n == (op_a <= op_b))
                else $error("magnitude mismatch"); // R5
            AST_SUB_EQUAL: assert (!(!logic_mode && fn_sel == 4'b0110 && carry_in_n) || all_ones == (op_a == op_b))
                else $error("equality mismatch"); // R6
            AST_GROUP_CARRY: assert (~carry_out_n == (~grp_gen_n | (~grp_prop_n & ~carry_in_n)))
                else $error("group carry mismatch"); // R7
        end
    end

endmodule

bind alu4_slice alu4_slice_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a        (op_a),
    .op_b        (op_b),
    .fn_sel      (fn_sel),
    .logic_mode  (logic_mode),
    .carry_in_n  (carry_in_n),
    .result      (result),
    .carry_out_n (carry_out_n),
    .grp_prop_n  (grp_prop_n),
    .grp_gen_n   (grp_gen_n),
    .all_ones    (all_ones)
);

// File: tb/sim_alu4_slice.sv
module sim_alu4_slice;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_a = '0;
    logic [3:0] op_b = '0;
    logic [3:0] fn_sel = '0;
    logic       logic_mode = 1'b0;
    logic       carry_in_n = 1'b1;
    logic [3:0] result;
    logic       carry_out_n;
    logic       grp_prop_n;
    logic       grp_gen_n;
    logic       all_ones;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    alu4_slice u0 (
        .op_a        (op_a),
        .op_b        (op_b),
        .fn_sel      (fn_sel),
        .logic_mode  (logic_mode),
        .carry_in_n  (carry_in_n),
        .result      (result),
        .carry_out_n (carry_out_n),
        .grp_prop_n  (grp_prop_n),
        .grp_gen_n   (grp_gen_n),
        .all_ones    (all_ones)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_err = n_err + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_err = n_err + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bitwise function table (R1).
    function automatic logic [3:0] ref_logic(input logic [3:0] s, input logic [3:0] a, input logic [3:0] b);
        case (s)
            4'b0000: return ~a;
            4'b0001: return ~(a | b);
            4'b0010: return ~a & b;
            4'b0011: return 4'b0000;
            4'b0100: return ~(a & b);
            4'b0101: return ~b;
            4'b0110: return a ^ b;
            4'b0111: return a & ~b;
            4'b1000: return ~a | b;
            4'b1001: return ~(a ^ b);
            4'b1010: return b;
            4'b1011: return a & b;
            4'b1100: return 4'b1111;
            4'b1101: return a | ~b;
            4'b1110: return a | b;
            default: return a;
        endcase
    endfunction

    // Addends of the arithmetic table (R2, R3); "minus 1" entries add all ones.
    function automatic logic [9:0] ref_terms(input logic [3:0] s, input logic [3:0] a, input logic [3:0] b);
        logic [4:0] x;
        logic [4:0] y;
        case (s)
            4'b0000: begin x = {1'b0, a};        y = 5'd0; end
            4'b0001: begin x = {1'b0, a | b};    y = 5'd0; end
            4'b0010: begin x = {1'b0, a | ~b};   y = 5'd0; end
            4'b0011: begin x = 5'd15;            y = 5'd0; end
            4'b0100: begin x = {1'b0, a};        y = {1'b0, a & ~b}; end
            4'b0101: begin x = {1'b0, a | b};    y = {1'b0, a & ~b}; end
            4'b0110: begin x = {1'b0, a};        y = {1'b0, ~b}; end
            4'b0111: begin x = {1'b0, a & ~b};   y = 5'd15; end
            4'b1000: begin x = {1'b0, a};        y = {1'b0, a & b}; end
            4'b1001: begin x = {1'b0, a};        y = {1'b0, b}; end
            4'b1010: begin x = {1'b0, a | ~b};   y = {1'b0, a & b}; end
            4'b1011: begin x = {1'b0, a & b};    y = 5'd15; end
            4'b1100: begin x = {1'b0, a};        y = {1'b0, a}; end
            4'b1101: begin x = {1'b0, a | b};    y = {1'b0, a}; end
            4'b1110: begin x = {1'b0, a | ~b};   y = {1'b0, a}; end
            default: begin x = {1'b0, a};        y = 5'd15; end
        endcase
        return {x, y};
    endfunction

    task automatic drive(input logic [3:0] a, input logic [3:0] b, input logic [3:0] s,
                         input logic m, input logic cn);
        @(posedge clk);
        op_a       <= a;
        op_b       <= b;
        fn_sel     <= s;
        logic_mode <= m;
        carry_in_n <= cn;
        @(negedge clk);
    endtask

    task automatic check_all(input logic [3:0] a, input logic [3:0] b, input logic [3:0] s,
                             input logic m, input logic cn);
        logic [9:0] xy;
        logic [4:0] sum;
        logic [4:0] sum0;
        logic [3:0] u;
        logic [3:0] f_exp;
        logic       p_exp;
        logic       g_exp;
        xy    = ref_terms(s, a, b);
        sum   = xy[9:5] + xy[4:0] + {4'b0, ~cn};
        sum0  = xy[9:5] + xy[4:0];
        u     = a | (s[0] ? b : 4'b0) | (s[1] ? ~b : 4'b0);
        p_exp = &u;
        g_exp = sum0[4];
        f_exp = m ? ref_logic(s, a, b) : sum[3:0];
        if (m) chk(result == f_exp, "R1 logic result", {4'b0, result}, {4'b0, f_exp});
        else   chk(result == f_exp, "R2 arith result", {4'b0, result}, {4'b0, f_exp});
        chk(carry_out_n == ~sum[4], m ? "R8 carry in logic mode" : "R4 carry out",
            {7'b0, carry_out_n}, {7'b0, ~sum[4]});
        chk(grp_prop_n == ~p_exp, m ? "R8 prop in logic mode" : "R7 group propagate",
            {7'b0, grp_prop_n}, {7'b0, ~p_exp});
        chk(grp_gen_n == ~g_exp, m ? "R8 gen in logic mode" : "R7 group generate",
            {7'b0, grp_gen_n}, {7'b0, ~g_exp});
        chk(all_ones == (&f_exp), "R6 all ones flag", {7'b0, all_ones}, {7'b0, &f_exp});
        if (!m && s == 4'b0110) begin
            if (cn) begin
                chk(carry_out_n == (a <= b), "R5 magnitude no carry", {7'b0, carry_out_n}, {7'b0, a <= b});
                chk(all_ones == (a == b), "R6 equality", {7'b0, all_ones}, {7'b0, a == b});
            end else begin
                chk(carry_out_n == (a < b), "R5 magnitude with carry", {7'b0, carry_out_n}, {7'b0, a < b});
            end
        end
    endtask

    task automatic direct(input logic [3:0] a, input logic [3:0] b, input logic [3:0] s,
                          input logic cn, input logic [3:0] f_exp, input logic co_n_exp);
        drive(a, b, s, 1'b0, cn);
        chk(result == f_exp, "R3 directed result", {4'b0, result}, {4'b0, f_exp});
        chk(carry_out_n == co_n_exp, "R3 directed carry", {7'b0, carry_out_n}, {7'b0, co_n_exp});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset-time idle inputs: A=0, B=0, code 0000, arithmetic, no carry.
        chk(result == 4'h0, "R2 idle result", {4'b0, result}, 8'h00);
        chk(carry_out_n == 1'b1, "R4 idle carry", {7'b0, carry_out_n}, 8'h01);
        chk(all_ones == 1'b0, "R6 idle flag", {7'b0, all_ones}, 8'h00);

        // R3 directed corner cases.
        direct(4'd9,  4'd8,  4'b1001, 1'b1, 4'd1,  1'b0);
        direct(4'd15, 4'd0,  4'b1001, 1'b0, 4'd0,  1'b0);
        direct(4'd5,  4'd5,  4'b0110, 1'b0, 4'd0,  1'b0);
        direct(4'd5,  4'd5,  4'b0110, 1'b1, 4'd15, 1'b1);
        direct(4'd3,  4'd7,  4'b0110, 1'b0, 4'd12, 1'b1);
        direct(4'b1011, 4'd0, 4'b1100, 1'b1, 4'b0110, 1'b0);
        direct(4'd0,  4'd6,  4'b1111, 1'b1, 4'd15, 1'b1);
        direct(4'd15, 4'd6,  4'b0000, 1'b0, 4'd0,  1'b0);
        direct(4'd7,  4'd2,  4'b0011, 1'b1, 4'd15, 1'b1);
        direct(4'd7,  4'd2,  4'b0011, 1'b0, 4'd0,  1'b0);

        // Exhaustive sweep of every input combination.
        for (int v = 0; v < 16384; v++) begin
            logic [13:0] w;
            w = 14'(v);
            drive(w[3:0], w[7:4], w[11:8], w[12], w[13]);
            check_all(w[3:0], w[7:4], w[11:8], w[12], w[13]);
        end

        // Random pass with a fixed seed, weighted toward the subtract code.
        void'($urandom(32'h1d2c3b4a));
        for (int k = 0; k < 2000; k++) begin
            logic [31:0] r;
            logic [3:0]  s;
            r = $urandom();
            s = (r[20:18] == 3'd0) ? 4'b0110 : r[11:8];
            drive(r[3:0], r[7:4], s, r[12], r[13]);
            check_all(r[3:0], r[7:4], s, r[12], r[13]);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule